// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the next level of memory and makes stores asynchronous. The processor side hands it a store: a byte address, one data word and per-byte enables. The store counts as complete in the cycle it is accepted. The block keeps each store in a block-sized entry. An entry holds the block address, the data for every word slot of the block and a per-byte valid mask. Entries leave through a downstream valid/ready port, oldest first, one whole block per handshake.

A store whose block address matches an entry that is still waiting is folded into that entry: its enabled bytes overwrite the stored bytes, and its enables are ORed into the mask. The oldest entry is always offered downstream, so it is treated as being in flight and is never a merge target. A store that falls inside a parameterised I/O address window, or that carries the no-merge flag, always gets an entry of its own. Later stores also never merge into such an entry.

Occupancy is tracked by a three-state machine. `WB_EMPTY` goes to `WB_PARTIAL` on an allocation. `WB_PARTIAL` goes to `WB_FULL` when an allocation without a drain takes the last free entry. `WB_PARTIAL` goes back to `WB_EMPTY` when a drain without an allocation removes the only entry. `WB_FULL` goes to `WB_PARTIAL` on a drain without an allocation. All other cycles hold the state. A merge changes no state.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dn_valid` is 0 and `st_ready` is 1.
- R2: A store to a block not held in any eligible entry allocates a new entry. Entries are offered on the downstream port in allocation order. `dn_addr` is the block address with the low offset bits zero. Word slot k of the block occupies `dn_data` bits [k*32 +: 32] and `dn_be` bits [k*4 +: 4].
- R3: A store to the same block as a waiting entry that is not the oldest is merged into that entry. The merged entry's `dn_be` is the OR of all enables, the latest store wins on overlapping bytes, and no extra downstream transfer appears.
- R4: The oldest entry, which is being offered downstream, is never a merge target. A store to its block allocates a new entry.
- R5: A store whose address lies in [IO_BASE, IO_LIMIT] never merges into an existing entry. Later stores never merge into it either.
- R6: A store with `st_nomerge` = 1 behaves like an I/O store for merging, whatever its address.
- R7: When every entry is occupied, `st_ready` is 0 for a store that cannot merge and 1 for a store that can.
- R8: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid`, `dn_addr`, `dn_be` and `dn_data` hold their values.
- R9: A store accepted in the same cycle as a downstream handshake is kept, and the next entry becomes visible in the following cycle.
- R10: Bytes of an entry that no store enabled read as zero on `dn_data`, and their `dn_be` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Byte address of the store |
| st_data | input | DATA_W | Store data word |
| st_be | input | DATA_W/8 | Byte enables of the word |
| st_nomerge | input | 1 | Force a private entry for this store |
| dn_valid | output | 1 | Oldest entry offered downstream |
| dn_ready | input | 1 | Downstream takes the offered entry |
| dn_addr | output | ADDR_W | Block-aligned address of the offered entry |
| dn_data | output | DATA_W*WORDS_PER_BLK | Block data of the offered entry |
| dn_be | output | DATA_W/8*WORDS_PER_BLK | Byte valid mask of the offered entry |

## Verification
The bench uses the defaults: four entries, four 32-bit words per block, and an I/O window covering the top sixteenth of a 32-bit address space. With only four entries, the full condition is reached after four stores. That makes it possible to see both a refused new block and an accepted merge while full. It also leaves room to line up a head entry, a merge target and an I/O or no-merge entry in one burst. Holding `dn_ready` low keeps the head in flight for as long as a scenario needs, so head exclusion and output stability are observable.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
    typedef enum logic [1:0] {
        WB_EMPTY   = 2'd0,
        WB_PARTIAL = 2'd1,
        WB_FULL    = 2'd2
    } wb_state_e;
endpackage

// File: rtl/wbuf_match.sv
`timescale 1ns/1ps
module wbuf_match #(
    parameter int NUM_ENTRIES = 4,
    parameter int BLK_AW      = 28,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ENTRIES-1:0][BLK_AW-1:0] cand_blk,
    input  logic [NUM_ENTRIES-1:0]             eligible,
    input  logic [BLK_AW-1:0]                  req_blk,
    input  logic                               req_private,
    output logic                               hit,
    output logic [IDX_W-1:0]                   hit_idx
);
    logic [NUM_ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = eligible[g] && !req_private && (cand_blk[g] == req_blk);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R3: at most one waiting entry can hold a given block
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
endmodule

// File: rtl/wbuf_ctrl.sv
`timescale 1ns/1ps
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NUM_ENTRIES);

    wb_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [IDX_W-1:0] head_q, tail_q;

    always_comb begin
        count_d = count_q;
        if (alloc && !pop)      count_d = count_q + 1'b1;
        else if (pop && !alloc) count_d = count_q - 1'b1;

        state_d = state_q;
        unique case (state_q)
            WB_EMPTY: begin
                if (alloc) state_d = (count_d == CNT_MAX) ? WB_FULL : WB_PARTIAL;
            end
            WB_PARTIAL: begin
                if (alloc && !pop && count_d == CNT_MAX) state_d = WB_FULL;
                else if (pop && !alloc && count_d == '0) state_d = WB_EMPTY;
            end
            WB_FULL: begin
                if (pop && !alloc) state_d = WB_PARTIAL;
            end
            default: state_d = WB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WB_EMPTY;
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (pop)   head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
            if (alloc) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
        end
    end

    always_comb begin
        full     = (state_q == WB_FULL);
        empty    = (state_q == WB_EMPTY);
        head_idx = head_q;
        tail_idx = tail_q;
    end

    // R7: no allocation is ever granted while every entry is taken
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WB_FULL) |-> !alloc);
    // R2: nothing drains from an empty buffer
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WB_EMPTY) |-> !pop);
    // R9: simultaneous allocate and drain keep occupancy unchanged
    a_r9_push_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && pop) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/merge_wbuf.sv
`timescale 1ns/1ps
module merge_wbuf #(
    parameter int              NUM_ENTRIES   = 4,
    parameter int              ADDR_W        = 32,
    parameter int              DATA_W        = 32,
    parameter int              WORDS_PER_BLK = 4,
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] IO_LIMIT    = 32'hFFFF_FFFF,
    localparam int             BYTES_W       = DATA_W / 8,
    localparam int             BLK_BYTES     = BYTES_W * WORDS_PER_BLK,
    localparam int             BLK_BITS      = DATA_W * WORDS_PER_BLK,
    localparam int             BOFF_W        = $clog2(BYTES_W),
    localparam int             WSEL_W        = $clog2(WORDS_PER_BLK),
    localparam int             OFF_W         = BOFF_W + WSEL_W,
    localparam int             BLK_AW        = ADDR_W - OFF_W,
    localparam int             IDX_W         = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [BYTES_W-1:0]   st_be,
    input  logic                 st_nomerge,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [ADDR_W-1:0]    dn_addr,
    output logic [BLK_BITS-1:0]  dn_data,
    output logic [BLK_BYTES-1:0] dn_be
);
    logic [NUM_ENTRIES-1:0][BLK_AW-1:0]    ent_blk;
    logic [NUM_ENTRIES-1:0][BLK_BITS-1:0]  ent_data;
    logic [NUM_ENTRIES-1:0][BLK_BYTES-1:0] ent_be;
    logic [NUM_ENTRIES-1:0]                ent_valid;
    logic [NUM_ENTRIES-1:0]                ent_priv;
    logic [NUM_ENTRIES-1:0]                eligible;

    logic [IDX_W-1:0]     head_idx, tail_idx, hit_idx;
    logic                 full, empty, hit;
    logic                 req_private, accept, alloc, merge, pop;
    logic [BLK_AW-1:0]    req_blk;
    logic [WSEL_W-1:0]    word_sel;
    logic [BLK_BYTES-1:0] new_be;
    logic [BLK_BITS-1:0]  new_data, new_bits;

    assign req_blk     = st_addr[ADDR_W-1:OFF_W];
    assign word_sel    = st_addr[OFF_W-1:BOFF_W];
    assign req_private = st_nomerge || ((st_addr >= IO_BASE) && (st_addr <= IO_LIMIT));

    always_comb begin
        new_be   = BLK_BYTES'(st_be) << (word_sel * BYTES_W);
        new_data = BLK_BITS'(st_data) << (word_sel * DATA_W);
        for (int b = 0; b < BLK_BYTES; b++) begin
            new_bits[b*8 +: 8] = {8{new_be[b]}};
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_elig
        assign eligible[g] = ent_valid[g] && !ent_priv[g] && (IDX_W'(g) != head_idx);
    end

    wbuf_match #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .BLK_AW      (BLK_AW)
    ) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_blk    (ent_blk),
        .eligible    (eligible),
        .req_blk     (req_blk),
        .req_private (req_private),
        .hit         (hit),
        .hit_idx     (hit_idx)
    );

    assign st_ready = hit || !full;
    assign accept   = st_valid && st_ready;
    assign merge    = accept && hit;
    assign alloc    = accept && !hit;
    assign dn_valid = !empty;
    assign pop      = dn_valid && dn_ready;

    wbuf_ctrl #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_priv  <= '0;
            ent_be    <= '0;
            ent_blk   <= '0;
            ent_data  <= '0;
        end else begin
            if (pop) begin
                ent_valid[head_idx] <= 1'b0;
            end
            if (alloc) begin
                ent_valid[tail_idx] <= 1'b1;
                ent_priv[tail_idx]  <= req_private;
                ent_blk[tail_idx]   <= req_blk;
                ent_be[tail_idx]    <= new_be;
                ent_data[tail_idx]  <= new_data & new_bits;
            end
            if (merge) begin
                ent_be[hit_idx]   <= ent_be[hit_idx] | new_be;
                ent_data[hit_idx] <= (ent_data[hit_idx] & ~new_bits) | (new_data & new_bits);
            end
        end
    end

    always_comb begin
        dn_addr = {ent_blk[head_idx], OFF_W'(0)};
        dn_data = ent_data[head_idx];
        dn_be   = ent_be[head_idx];
    end

    // R8: an offered entry does not change until it is taken
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_be) && $stable(dn_data)));
    // R5, R6: a private store never merges
    a_r5_private_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && req_private) |-> !hit);
    // R4: the entry on offer is never the merge target
    a_r4_head_not_target: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && dn_valid) |-> (hit_idx != head_idx));
endmodule

// File: tb/sim_merge_wbuf.sv
`timescale 1ns/1ps
module sim_merge_wbuf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         st_nomerge = 1'b0;
    logic         dn_valid;
    logic         dn_ready = 1'b0;
    logic [31:0]  dn_addr;
    logic [127:0] dn_data;
    logic [15:0]  dn_be;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    merge_wbuf u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_nomerge(st_nomerge),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_data(dn_data), .dn_be(dn_be)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                        input logic nm, input string req);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_nomerge = nm;
        #1 chk(req, 160'(st_ready), 160'(1'b1));
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic probe_ready(input logic [31:0] a, input logic nm, input logic exp,
                               input string req);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = 32'hDEAD_BEEF; st_be = 4'hF; st_nomerge = nm;
        #1 chk(req, 160'(st_ready), 160'(exp));
        st_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic [31:0] a, input logic [15:0] be, input logic [127:0] d,
                           input string req);
        @(negedge clk);
        dn_ready = 1'b1;
        #1 chk(req, {dn_valid, dn_addr, dn_be, dn_data}, {1'b1, a, be, d});
        @(posedge clk);
        #1 dn_ready = 1'b0;
    endtask

    task automatic empty_chk(input string req);
        @(negedge clk);
        chk(req, 160'(dn_valid), 160'(1'b0));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 160'(st_ready), 160'(1'b1));
        chk("R1 reset empty", 160'(dn_valid), 160'(1'b0));
    endtask

    task automatic t_order_and_hold;
        push(32'h0000_0100, 32'h1111_1111, 4'hF, 1'b0, "R2 push A");
        push(32'h0000_0204, 32'h2222_2222, 4'hF, 1'b0, "R2 push B");
        push(32'h0000_030C, 32'h3333_3333, 4'h3, 1'b0, "R2 push C");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 held offer", {dn_valid, dn_addr, dn_be, dn_data},
                {1'b1, 32'h0000_0100, 16'h000F, 128'h1111_1111});
        end
        pop_chk(32'h0000_0100, 16'h000F, 128'h1111_1111, "R2 first");
        pop_chk(32'h0000_0200, 16'h00F0, {32'h0, 32'h0, 32'h2222_2222, 32'h0}, "R2 second");
        pop_chk(32'h0000_0300, 16'h3000, {32'h0000_3333, 96'h0}, "R10 partial word");
        empty_chk("R2 drained");
    endtask

    task automatic t_merge;
        push(32'h0000_0100, 32'h1111_1111, 4'hF, 1'b0, "R3 head");
        push(32'h0000_0200, 32'hAAAA_AAAA, 4'hF, 1'b0, "R3 first");
        push(32'h0000_0208, 32'h1234_5678, 4'h3, 1'b0, "R3 merge word2");
        push(32'h0000_0200, 32'h0000_00BB, 4'h1, 1'b0, "R3 overwrite byte");
        pop_chk(32'h0000_0100, 16'h000F, 128'h1111_1111, "R3 head out");
        pop_chk(32'h0000_0200, 16'h030F, {32'h0, 32'h0000_5678, 32'h0, 32'hAAAA_AABB},
                "R3 merged block");
        empty_chk("R3 single transfer");
    endtask

    task automatic t_head_excluded;
        push(32'h0000_0400, 32'h4444_4444, 4'hF, 1'b0, "R4 head");
        push(32'h0000_0404, 32'h5555_5555, 4'hF, 1'b0, "R4 same block");
        pop_chk(32'h0000_0400, 16'h000F, 128'h4444_4444, "R4 head alone");
        pop_chk(32'h0000_0400, 16'h00F0, {64'h0, 32'h5555_5555, 32'h0}, "R4 new entry");
        empty_chk("R4 drained");
    endtask

    task automatic t_io;
        push(32'h0000_0100, 32'h1111_1111, 4'hF, 1'b0, "R5 head");
        push(32'hF000_0000, 32'h6666_6666, 4'hF, 1'b0, "R5 io a");
        push(32'hF000_0004, 32'h7777_7777, 4'hF, 1'b0, "R5 io b");
        pop_chk(32'h0000_0100, 16'h000F, 128'h1111_1111, "R5 head out");
        pop_chk(32'hF000_0000, 16'h000F, 128'h6666_6666, "R5 io a separate");
        pop_chk(32'hF000_0000, 16'h00F0, {64'h0, 32'h7777_7777, 32'h0}, "R5 io b separate");
        empty_chk("R5 drained");
    endtask

    task automatic t_nomerge;
        push(32'h0000_0100, 32'h1111_1111, 4'hF, 1'b0, "R6 head");
        push(32'h0000_0500, 32'h8888_8888, 4'hF, 1'b1, "R6 flagged");
        push(32'h0000_0504, 32'h9999_9999, 4'hF, 1'b0, "R6 after flagged");
        push(32'h0000_0508, 32'hCCCC_CCCC, 4'hF, 1'b0, "R6 merge plain");
        pop_chk(32'h0000_0100, 16'h000F, 128'h1111_1111, "R6 head out");
        pop_chk(32'h0000_0500, 16'h000F, 128'h8888_8888, "R6 flagged alone");
        pop_chk(32'h0000_0500, 16'h0FF0, {32'h0, 32'hCCCC_CCCC, 32'h9999_9999, 32'h0},
                "R6 plain merged");
        empty_chk("R6 drained");
    endtask

    task automatic t_full;
        push(32'h0000_0100, 32'h0000_0001, 4'hF, 1'b0, "R7 fill 1");
        push(32'h0000_0200, 32'h0000_0002, 4'hF, 1'b0, "R7 fill 2");
        push(32'h0000_0300, 32'h0000_0003, 4'hF, 1'b0, "R7 fill 3");
        push(32'h0000_0400, 32'h0000_0004, 4'hF, 1'b0, "R7 fill 4");
        probe_ready(32'h0000_0900, 1'b0, 1'b0, "R7 full refuses new block");
        probe_ready(32'h0000_0104, 1'b0, 1'b0, "R7 full refuses head block");
        push(32'h0000_0204, 32'h0000_0022, 4'hF, 1'b0, "R7 full accepts merge");
        pop_chk(32'h0000_0100, 16'h000F, 128'h1, "R7 out 1");
        pop_chk(32'h0000_0200, 16'h00FF, {64'h0, 32'h0000_0022, 32'h0000_0002}, "R7 out 2");
        pop_chk(32'h0000_0300, 16'h000F, 128'h3, "R7 out 3");
        pop_chk(32'h0000_0400, 16'h000F, 128'h4, "R7 out 4");
        empty_chk("R7 drained");
    endtask

    task automatic t_concurrent;
        push(32'h0000_0100, 32'h0000_00A1, 4'hF, 1'b0, "R9 first");
        @(negedge clk);
        dn_ready = 1'b1;
        st_valid = 1'b1; st_addr = 32'h0000_0200; st_data = 32'h0000_00B2;
        st_be = 4'hF; st_nomerge = 1'b0;
        #1 chk("R9 both sides", {dn_valid, st_ready, dn_addr}, {1'b1, 1'b1, 32'h0000_0100});
        @(posedge clk);
        #1 begin dn_ready = 1'b0; st_valid = 1'b0; end
        pop_chk(32'h0000_0200, 16'h000F, 128'hB2, "R9 store kept");
        empty_chk("R9 drained");
    endtask

    initial begin
        t_reset();
        t_order_and_hold();
        t_merge();
        t_head_excluded();
        t_io();
        t_nomerge();
        t_full();
        t_concurrent();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule